// File: doc/BRIEF.md
# USB Device Suspend and Wake Detector

This block watches the decoded state of a full-speed USB data line pair and raises two interrupt flags for a device controller. The suspend flag reports a long stretch of bus idle. The wake flag reports line activity. The block also holds the control bit that connects or disconnects the D+ pull-up, and the device address register together with its enable bit.

The line state first passes through a two-flop synchronizer. A prescaler makes one-microsecond ticks from the system clock. The suspend flag is raised once for each idle period, after the line has stayed in J for the whole configured idle time. The wake flag is raised on every change from J to a non-idle state, whether or not a suspend came first. Each flag clears the other when it is set. Firmware clears a flag with a one-cycle strobe. A separate enable bit for each flag gates it onto the interrupt request.

The pull-up is disconnected after reset. Firmware connects it by clearing the detach bit. If firmware sets the bit and then clears it again, the host sees the device leave and return, which makes it enumerate the device again. The device address reads as zero until the address enable bit is set. Both the address and its enable bit are cleared on a bus reset, and the enable bit is also cleared while the USB macro is disabled.

Top module: `usb_susp_wake_ctrl`

## Requirements
- R1: After reset, both flags, irq, pullup_en and dev_addr are 0.
- R2: Line code 2'b01 is J; 2'b10 (K), 2'b00 (SE0) and 2'b11 are non-idle. Let N = IDLE_TIME_US * CLK_FREQ_HZ / 1e6. If line_state is J at N consecutive rising edges (the first of these edges being the first one that sees J), susp_flag rises at the second edge after the last of them, and not before.
- R3: Within one unbroken J period, susp_flag is raised only once. After firmware clears it, it stays 0 for as long as the line remains J.
- R4: Any non-J sample restarts the idle count. J runs shorter than N edges, each separated by a non-J sample, never raise susp_flag.
- R5: wake_flag rises at the third rising edge after line_state first goes from J to a non-idle value. This happens whether or not susp_flag is set. A non-idle level that is simply held does not raise wake_flag again after it has been cleared.
- R6: When wake_flag is set, susp_flag is cleared. When susp_flag is set, wake_flag is cleared. The two flags are never 1 at the same time.
- R7: A one-cycle pulse on clr_susp or clr_wake clears the matching flag at the next edge. If a set event lands on the same edge as the clear, the flag stays set.
- R8: irq = (susp_flag & suspend enable) | (wake_flag & wake enable). The enables are written with ien_wr and change on the same edge as the write.
- R9: The detach bit resets to 1 and pullup_en = !detach. A write with detach_wr takes effect at the next edge.
- R10: An addr_wr pulse loads addr_val and addr_en_val. dev_addr equals the stored address while the enable bit is 1, and equals 0 while it is 0. bus_reset clears both the address and the enable bit, and takes priority over a write in the same cycle.
- R11: While usb_en is 0, the address enable bit is held at 0, so dev_addr is 0. The bit stays 0 after usb_en returns to 1, until it is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| bus_reset | input | 1 | USB bus reset has been received |
| usb_en | input | 1 | USB macro enable |
| line_state | input | 2 | Decoded line state (01 J, 10 K, 00 SE0) |
| detach_wr | input | 1 | Write strobe for the detach bit |
| detach_val | input | 1 | New detach value |
| addr_wr | input | 1 | Write strobe for the address and its enable bit |
| addr_val | input | ADDR_W | New device address |
| addr_en_val | input | 1 | New address enable value |
| ien_wr | input | 1 | Write strobe for the interrupt enables |
| susp_ie_val | input | 1 | New suspend interrupt enable |
| wake_ie_val | input | 1 | New wake interrupt enable |
| clr_susp | input | 1 | Clear strobe for the suspend flag |
| clr_wake | input | 1 | Clear strobe for the wake flag |
| susp_flag | output | 1 | Suspend flag |
| wake_flag | output | 1 | Wake flag |
| irq | output | 1 | Interrupt request |
| pullup_en | output | 1 | D+ pull-up connect |
| dev_addr | output | ADDR_W | Device address in effect |

## Verification
The hardest case to reach is a set event and a firmware clear strobe landing on the same edge. The strobe has to be placed in the exact cycle at which the idle count finishes or the J-to-K change reaches the end of the synchronizer. The bench works out that cycle from N and the two synchronizer stages, and pulses the clear strobe there. The bench also sweeps every J-run length from 1 to N-1, separated by short K bursts, to show that the idle count restarts and never fires early.

// File: rtl/usb_sw_pkg.sv
package usb_sw_pkg;
  typedef enum logic [1:0] {
    LINE_SE0 = 2'b00,
    LINE_J   = 2'b01,
    LINE_K   = 2'b10,
    LINE_BAD = 2'b11
  } line_t;
endpackage

// File: rtl/usb_sw_line_sync.sv
module usb_sw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        line_raw,
  output usb_sw_pkg::line_t line_sync
);
  import usb_sw_pkg::*;

  localparam int SH_W = 2 * STAGES;

  logic [SH_W-1:0] shreg;

  // Reset fills the chain with idle, so no false activity is seen after reset
  always_ff @(posedge clk) begin
    if (rst) shreg <= {STAGES{LINE_J}};
    else     shreg <= {shreg[SH_W-3:0], line_raw};
  end

  assign line_sync = line_t'(shreg[SH_W-1:SH_W-2]);
endmodule

// File: rtl/usb_sw_idle_timer.sv
module usb_sw_idle_timer #(
  parameter int CLK_FREQ_HZ  = 48_000_000,
  parameter int IDLE_TIME_US = 3000
) (
  input  logic              clk,
  input  logic              rst,
  input  usb_sw_pkg::line_t line,
  output logic              susp_evt,
  output logic              wake_evt
);
  import usb_sw_pkg::*;

  localparam int DIV      = (CLK_FREQ_HZ / 1_000_000 < 1) ? 1 : CLK_FREQ_HZ / 1_000_000;
  localparam int US_W     = (IDLE_TIME_US > 1) ? $clog2(IDLE_TIME_US) : 1;
  localparam int IDLE_CYC = DIV * IDLE_TIME_US;
  localparam logic [US_W-1:0] US_LAST = US_W'(IDLE_TIME_US - 1);

  logic            is_j;
  logic            prev_j;
  logic            done;
  logic            tick;
  logic [US_W-1:0] us_cnt;

  assign is_j = (line == LINE_J);

  // Microsecond tick: the prescaler is left out when the clock runs at 1 MHz
  generate
    if (DIV == 1) begin : g_no_prescale
      assign tick = is_j;
    end else begin : g_prescale
      localparam int PRE_W = $clog2(DIV);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);
      logic [PRE_W-1:0] pre_cnt;
      always_ff @(posedge clk) begin
        if (rst || !is_j || done) pre_cnt <= '0;
        else if (pre_cnt == PRE_LAST) pre_cnt <= '0;
        else pre_cnt <= pre_cnt + 1'b1;
      end
      assign tick = is_j && (pre_cnt == PRE_LAST);
    end
  endgenerate

  // Idle microsecond count; done marks that this idle run has already fired
  always_ff @(posedge clk) begin
    if (rst || !is_j) begin
      us_cnt <= '0;
      done   <= 1'b0;
    end else if (!done && tick) begin
      if (us_cnt == US_LAST) begin
        us_cnt <= '0;
        done   <= 1'b1;
      end else begin
        us_cnt <= us_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_j <= 1'b1;
    else     prev_j <= is_j;
  end

  assign susp_evt = is_j && !done && tick && (us_cnt == US_LAST);
  assign wake_evt = prev_j && !is_j;

  // Independent run-length counter used only by the checks below
  logic [31:0] jrun;
  always_ff @(posedge clk) begin
    if (rst || !is_j) jrun <= '0;
    else if (jrun < IDLE_CYC) jrun <= jrun + 1;
  end

  AST_SUSP_AFTER_FULL_IDLE: assert property (@(posedge clk) disable iff (rst)
    susp_evt |-> (jrun == IDLE_CYC - 1)); // R2
  AST_ONE_SUSP_PER_RUN: assert property (@(posedge clk) disable iff (rst)
    (is_j && jrun >= IDLE_CYC) |-> !susp_evt); // R3
  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (rst)
    !is_j |=> !susp_evt); // R4
endmodule

// File: rtl/usb_sw_flags.sv
module usb_sw_flags (
  input  logic clk,
  input  logic rst,
  input  logic susp_evt,
  input  logic wake_evt,
  input  logic clr_susp,
  input  logic clr_wake,
  input  logic ien_wr,
  input  logic susp_ie_val,
  input  logic wake_ie_val,
  output logic susp_flag,
  output logic wake_flag,
  output logic irq
);
  logic susp_n, wake_n, sie_n, wie_n;
  logic sie_q, wie_q;

  // A set event wins over both the firmware clear and the cross clear
  always_comb begin
    susp_n = susp_flag;
    if (susp_evt)                 susp_n = 1'b1;
    else if (wake_evt || clr_susp) susp_n = 1'b0;

    wake_n = wake_flag;
    if (wake_evt)                  wake_n = 1'b1;
    else if (susp_evt || clr_wake) wake_n = 1'b0;

    sie_n = ien_wr ? susp_ie_val : sie_q;
    wie_n = ien_wr ? wake_ie_val : wie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      susp_flag <= 1'b0;
      wake_flag <= 1'b0;
      sie_q     <= 1'b0;
      wie_q     <= 1'b0;
      irq       <= 1'b0;
    end else begin
      susp_flag <= susp_n;
      wake_flag <= wake_n;
      sie_q     <= sie_n;
      wie_q     <= wie_n;
      irq       <= (susp_n & sie_n) | (wake_n & wie_n);
    end
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(susp_flag && wake_flag)); // R6
  AST_SUSP_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    susp_evt |=> susp_flag); // R7
  AST_WAKE_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    wake_evt |=> wake_flag); // R7
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (clr_susp && !susp_evt) |=> !susp_flag); // R7
endmodule

// File: rtl/usb_sw_regs.sv
module usb_sw_regs #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_reset,
  input  logic              usb_en,
  input  logic              detach_wr,
  input  logic              detach_val,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic              addr_en_val,
  output logic              pullup_en,
  output logic [ADDR_W-1:0] dev_addr
);
  logic              detach_q;
  logic [ADDR_W-1:0] addr_q;
  logic              addr_en_q;

  always_ff @(posedge clk) begin
    if (rst)            detach_q <= 1'b1;
    else if (detach_wr) detach_q <= detach_val;
  end

  always_ff @(posedge clk) begin
    if (rst || bus_reset) addr_q <= '0;
    else if (addr_wr)     addr_q <= addr_val;
  end

  always_ff @(posedge clk) begin
    if (rst || bus_reset || !usb_en) addr_en_q <= 1'b0;
    else if (addr_wr)                addr_en_q <= addr_en_val;
  end

  assign pullup_en = !detach_q;
  assign dev_addr  = addr_en_q ? addr_q : '0;

  AST_BUSRST_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(bus_reset) |-> (dev_addr == '0)); // R10
  AST_MACRO_OFF_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(!usb_en) |-> (dev_addr == '0)); // R11
  AST_DETACH_WRITE: assert property (@(posedge clk) disable iff (rst)
    $past(detach_wr) |-> (pullup_en == !$past(detach_val))); // R9
endmodule

// File: rtl/usb_susp_wake_ctrl.sv
module usb_susp_wake_ctrl #(
  parameter int CLK_FREQ_HZ  = 48_000_000,
  parameter int IDLE_TIME_US = 3000,
  parameter int SYNC_STAGES  = 2,
  parameter int ADDR_W       = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_reset,
  input  logic              usb_en,
  input  logic [1:0]        line_state,
  input  logic              detach_wr,
  input  logic              detach_val,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic              addr_en_val,
  input  logic              ien_wr,
  input  logic              susp_ie_val,
  input  logic              wake_ie_val,
  input  logic              clr_susp,
  input  logic              clr_wake,
  output logic              susp_flag,
  output logic              wake_flag,
  output logic              irq,
  output logic              pullup_en,
  output logic [ADDR_W-1:0] dev_addr
);
  import usb_sw_pkg::*;

  line_t sync_line;
  logic  susp_evt;
  logic  wake_evt;

  usb_sw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .line_raw  (line_state),
    .line_sync (sync_line)
  );

  usb_sw_idle_timer #(
    .CLK_FREQ_HZ  (CLK_FREQ_HZ),
    .IDLE_TIME_US (IDLE_TIME_US)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .line     (sync_line),
    .susp_evt (susp_evt),
    .wake_evt (wake_evt)
  );

  usb_sw_flags u_flags (
    .clk         (clk),
    .rst         (rst),
    .susp_evt    (susp_evt),
    .wake_evt    (wake_evt),
    .clr_susp    (clr_susp),
    .clr_wake    (clr_wake),
    .ien_wr      (ien_wr),
    .susp_ie_val (susp_ie_val),
    .wake_ie_val (wake_ie_val),
    .susp_flag   (susp_flag),
    .wake_flag   (wake_flag),
    .irq         (irq)
  );

  usb_sw_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .bus_reset   (bus_reset),
    .usb_en      (usb_en),
    .detach_wr   (detach_wr),
    .detach_val  (detach_val),
    .addr_wr     (addr_wr),
    .addr_val    (addr_val),
    .addr_en_val (addr_en_val),
    .pullup_en   (pullup_en),
    .dev_addr    (dev_addr)
  );

  AST_SUSP_ON_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(susp_flag) |-> ($past(sync_line) == LINE_J)); // R2
  AST_WAKE_ON_ACTIVITY: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_flag) |-> ($past(sync_line) != LINE_J)); // R5
endmodule

// File: tb/test_usb_susp_wake_ctrl.sv
module test_usb_susp_wake_ctrl;
  localparam int CLK_HZ = 2_000_000;
  localparam int IDLE_US = 8;
  localparam int N = (CLK_HZ / 1_000_000) * IDLE_US;
  localparam int AW = 7;
  localparam logic [1:0] J = 2'b01, K = 2'b10, SE0 = 2'b00;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_reset = 1'b0, usb_en = 1'b1;
  logic [1:0] line_state = J;
  logic detach_wr = 1'b0, detach_val = 1'b0;
  logic addr_wr = 1'b0, addr_en_val = 1'b0;
  logic [AW-1:0] addr_val = '0;
  logic ien_wr = 1'b0, susp_ie_val = 1'b0, wake_ie_val = 1'b0;
  logic clr_susp = 1'b0, clr_wake = 1'b0;
  logic susp_flag, wake_flag, irq, pullup_en;
  logic [AW-1:0] dev_addr;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  usb_susp_wake_ctrl #(
    .CLK_FREQ_HZ(CLK_HZ), .IDLE_TIME_US(IDLE_US), .SYNC_STAGES(2), .ADDR_W(AW)
  ) i_usb_susp_wake_ctrl (
    .clk(clk), .rst(rst), .bus_reset(bus_reset), .usb_en(usb_en),
    .line_state(line_state), .detach_wr(detach_wr), .detach_val(detach_val),
    .addr_wr(addr_wr), .addr_val(addr_val), .addr_en_val(addr_en_val),
    .ien_wr(ien_wr), .susp_ie_val(susp_ie_val), .wake_ie_val(wake_ie_val),
    .clr_susp(clr_susp), .clr_wake(clr_wake), .susp_flag(susp_flag),
    .wake_flag(wake_flag), .irq(irq), .pullup_en(pullup_en), .dev_addr(dev_addr)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_clr(input bit s, input bit w);
    clr_susp = s; clr_wake = w;
    step(1);
    clr_susp = 1'b0; clr_wake = 1'b0;
  endtask

  task automatic set_ien(input bit s, input bit w);
    ien_wr = 1'b1; susp_ie_val = s; wake_ie_val = w;
    step(1);
    ien_wr = 1'b0;
  endtask

  task automatic write_addr(input logic [AW-1:0] a, input bit en);
    addr_wr = 1'b1; addr_val = a; addr_en_val = en;
    step(1);
    addr_wr = 1'b0;
  endtask

  // Leave the line non-idle long enough that the idle count is reset
  task automatic go_busy();
    line_state = K;
    step(4);
  endtask

  // Full idle run; susp_flag rises at the (N+2)th edge after J is driven
  task automatic go_suspend();
    line_state = J;
    step(N + 2);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk("R1 susp", susp_flag, 0);
    chk("R1 wake", wake_flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 pullup", pullup_en, 0);
    chk("R1 addr", dev_addr, 0);

    // R2 exact suspend timing
    go_busy();
    pulse_clr(1, 1);
    line_state = J;
    step(N + 1);
    chk("R2 susp not yet", susp_flag, 0);
    step(1);
    chk("R2 susp set", susp_flag, 1);

    // R3 only once per idle run
    pulse_clr(1, 0);
    chk("R3 susp cleared", susp_flag, 0);
    step(3 * N);
    chk("R3 no second susp", susp_flag, 0);

    // R5 wake on activity without suspend; timing at third edge
    line_state = SE0;
    step(2);
    chk("R5 wake not yet", wake_flag, 0);
    step(1);
    chk("R5 wake on SE0", wake_flag, 1);
    pulse_clr(0, 1);
    step(2 * N);
    chk("R5 held level no retrigger", wake_flag, 0);

    // R4 restart: every short run length
    for (int l = 1; l < N; l++) begin
      line_state = J;
      step(l);
      line_state = K;
      step(3);
      chk("R4 short run no susp", susp_flag, 0);
    end
    pulse_clr(0, 1);
    go_suspend();
    chk("R4 full run after restarts", susp_flag, 1);

    // R6 cross clearing
    line_state = K;
    step(3);
    chk("R6 wake set", wake_flag, 1);
    chk("R6 susp cleared by wake", susp_flag, 0);
    go_suspend();
    chk("R6 susp set", susp_flag, 1);
    chk("R6 wake cleared by susp", wake_flag, 0);

    // R7 set wins over clear on same edge
    go_busy();
    pulse_clr(0, 1);
    line_state = J;
    step(N + 1);
    pulse_clr(1, 0);
    chk("R7 susp set beats clear", susp_flag, 1);
    line_state = K;
    step(2);
    pulse_clr(0, 1);
    chk("R7 wake set beats clear", wake_flag, 1);

    // R8 irq gating sweep over enables and flag states
    for (int e = 0; e < 4; e++) begin
      set_ien(e[0], e[1]);
      go_busy();
      pulse_clr(1, 1);
      chk("R8 irq no flags", irq, 0);
      go_suspend();
      chk("R8 irq susp", irq, {31'd0, e[0]});
      line_state = K;
      step(3);
      chk("R8 irq wake", irq, {31'd0, e[1]});
    end
    set_ien(0, 0);
    chk("R8 irq after disable", irq, 0);

    // R9 detach and pull-up
    detach_wr = 1'b1; detach_val = 1'b0;
    step(1);
    chk("R9 attach", pullup_en, 1);
    detach_val = 1'b1;
    step(1);
    chk("R9 detach", pullup_en, 0);
    detach_val = 1'b0;
    step(1);
    detach_wr = 1'b0;
    chk("R9 reattach", pullup_en, 1);

    // R10 address sweep with enable toggled
    for (int a = 0; a < (1 << AW); a++) begin
      write_addr(AW'(a), a[0]);
      chk("R10 addr", dev_addr, a[0] ? a : 0);
    end
    write_addr(7'h55, 1);
    chk("R10 addr 55", dev_addr, 32'h55);
    bus_reset = 1'b1; addr_wr = 1'b1; addr_val = 7'h12; addr_en_val = 1'b1;
    step(1);
    bus_reset = 1'b0; addr_wr = 1'b0;
    chk("R10 bus reset wins", dev_addr, 0);

    // R11 macro disable clears the enable bit
    write_addr(7'h2A, 1);
    chk("R11 addr set", dev_addr, 32'h2A);
    usb_en = 1'b0;
    step(1);
    chk("R11 macro off", dev_addr, 0);
    usb_en = 1'b1;
    step(1);
    chk("R11 stays off", dev_addr, 0);
    write_addr(7'h2A, 1);
    chk("R11 rewrite", dev_addr, 32'h2A);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule